// File: doc/BRIEF.md
# Cascadable Magnitude Comparator Stage

This block compares two unsigned words, `a_word` and `b_word`, and reports whether the first is greater than, less than or equal to the second. Bit `DATA_W-1` is the most significant. The comparison looks at the bit pairs from the top bit downward, and the highest pair that differs decides the result. Because only the ordering of bit patterns matters, the stage works for any code whose values rise monotonically with their binary pattern. Binary and BCD digits are both such codes.

Three carry-style inputs take the verdict of a less significant stage. The stage uses them only when its own two words match exactly. To build a ripple chain, the least significant stage ties its carry inputs to greater=0, less=0, equal=1. Each stage then feeds its three outputs into the carry inputs of the next more significant stage. The carry inputs also have a defined result for every combination that is not one-hot. A tree of stages can therefore use an unused carry pin as a fifth compare bit.

The stage is purely combinational, so all three outputs follow the present inputs. There is no clock and no state.

Top module: `mag_cmp_stage`

## Requirements
- R1: When the words differ, the highest differing bit position decides. If `a_word` holds the 1 there, the outputs are gt=1, lt=0. Otherwise they are gt=0, lt=1. The lower bits and the carry inputs have no effect.
- R2: Whenever `a_word` differs from `b_word`, `eq_o` is 0, for every value of the carry inputs.
- R3: With equal words and `casc_eq_i`=1, the outputs {gt,lt,eq} are {0,0,1}, for any `casc_gt_i` and `casc_lt_i`.
- R4: With equal words and carry inputs {gt,lt,eq}={1,0,0}, the outputs are {1,0,0}.
- R5: With equal words and carry inputs {0,1,0}, the outputs are {0,1,0}.
- R6: With equal words and carry inputs {1,1,0}, all three outputs are 0.
- R7: With equal words and carry inputs {0,0,0}, the outputs are {1,1,0}.
- R8: Two stages give a correct 2·`DATA_W`-bit compare of every word pair when connected as a ripple chain. In that chain the low stage's carry inputs are tied to {0,0,1}, and its outputs drive the high stage's carry inputs.
- R9: In the same two-stage chain, a pair of BCD digits per word (high digit in the high stage) gives the correct decimal ordering for all values 0 to 99.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_word | input | DATA_W | First operand, MSB at DATA_W-1 |
| b_word | input | DATA_W | Second operand, MSB at DATA_W-1 |
| casc_gt_i | input | 1 | Greater verdict from the less significant stage |
| casc_lt_i | input | 1 | Less verdict from the less significant stage |
| casc_eq_i | input | 1 | Equal verdict from the less significant stage |
| gt_o | output | 1 | a_word ranks above b_word |
| lt_o | output | 1 | a_word ranks below b_word |
| eq_o | output | 1 | Words match and the carry-in reports equality |

## Verification
The non-one-hot carry combinations matter only when the two words match exactly. A correctly tied chain never produces them. A random sweep of inputs would reach them only by chance. The bench therefore drives all eight carry patterns directly against every one of the 256 operand pairs, so each odd pattern is applied with equal words 16 times. A two-stage chain is also wired in the bench, and it is fed every 8-bit pair. This exercises the rule that a lower stage can decide the result only when the upper nibbles tie.

// File: rtl/mag_cmp_pkg.sv
package mag_cmp_pkg;
  // Verdict of a partial comparison.
  typedef enum logic [1:0] {
    REL_EQ = 2'd0,
    REL_GT = 2'd1,
    REL_LT = 2'd2
  } rel_e;
endpackage

// File: rtl/mag_cmp_bit.sv
module mag_cmp_bit
  import mag_cmp_pkg::*;
(
  input  logic a_bit,
  input  logic b_bit,
  output rel_e rel_o
);
  always_comb begin
    if (a_bit == b_bit) rel_o = REL_EQ;
    else if (a_bit)     rel_o = REL_GT;
    else                rel_o = REL_LT;
  end
endmodule

// File: rtl/mag_cmp_chain.sv
module mag_cmp_chain
  import mag_cmp_pkg::*;
#(
  parameter int DATA_W = 4
) (
  input  rel_e bit_rel_i [DATA_W],
  output rel_e word_rel_o
);
  localparam int TOP_BIT = DATA_W - 1;

  // The first non-equal verdict, scanning from the top, wins.
  always_comb begin
    word_rel_o = REL_EQ;
    for (int i = TOP_BIT; i >= 0; i--) begin
      if (word_rel_o == REL_EQ) word_rel_o = bit_rel_i[i];
    end
  end
endmodule

// File: rtl/mag_cmp_cascade.sv
module mag_cmp_cascade
  import mag_cmp_pkg::*;
(
  input  rel_e word_rel_i,
  input  logic casc_gt_i,
  input  logic casc_lt_i,
  input  logic casc_eq_i,
  output logic gt_o,
  output logic lt_o,
  output logic eq_o
);
  always_comb begin
    case (word_rel_i)
      REL_GT: {gt_o, lt_o, eq_o} = 3'b100;
      REL_LT: {gt_o, lt_o, eq_o} = 3'b010;
      default: begin
        // Equal words: the carry-in decides; the equal carry dominates,
        // and each ordered output survives unless the opposite carry or
        // the equal carry is raised.
        gt_o = ~casc_eq_i & ~casc_lt_i;
        lt_o = ~casc_eq_i & ~casc_gt_i;
        eq_o = casc_eq_i;
      end
    endcase
  end
endmodule

// File: rtl/mag_cmp_stage.sv
module mag_cmp_stage
  import mag_cmp_pkg::*;
#(
  parameter int DATA_W = 4
) (
  input  logic [DATA_W-1:0] a_word,
  input  logic [DATA_W-1:0] b_word,
  input  logic              casc_gt_i,
  input  logic              casc_lt_i,
  input  logic              casc_eq_i,
  output logic              gt_o,
  output logic              lt_o,
  output logic              eq_o
);
  rel_e bit_rel [DATA_W];
  rel_e word_rel;

  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    mag_cmp_bit u_bit (
      .a_bit (a_word[i]),
      .b_bit (b_word[i]),
      .rel_o (bit_rel[i])
    );
  end

  mag_cmp_chain #(.DATA_W(DATA_W)) u_chain (
    .bit_rel_i  (bit_rel),
    .word_rel_o (word_rel)
  );

  mag_cmp_cascade u_casc (
    .word_rel_i (word_rel),
    .casc_gt_i  (casc_gt_i),
    .casc_lt_i  (casc_lt_i),
    .casc_eq_i  (casc_eq_i),
    .gt_o       (gt_o),
    .lt_o       (lt_o),
    .eq_o       (eq_o)
  );
endmodule

// File: rtl/mag_cmp_stage_chk.sv
module mag_cmp_stage_chk #(
  parameter int DATA_W = 4
) (
  input logic [DATA_W-1:0] a_word,
  input logic [DATA_W-1:0] b_word,
  input logic              casc_gt_i,
  input logic              casc_lt_i,
  input logic              casc_eq_i,
  input logic              gt_o,
  input logic              lt_o,
  input logic              eq_o
);
  logic same;
  assign same = (a_word == b_word);

  always_comb begin
    if (a_word > b_word)
      assert_above_R1: assert (gt_o && !lt_o) else $error("R1 above");
    if (a_word < b_word)
      assert_below_R1: assert (lt_o && !gt_o) else $error("R1 below");
    if (!same)
      assert_noeq_R2: assert (!eq_o) else $error("R2 eq on differing words");
    if (same && casc_eq_i)
      assert_eqdom_R3: assert ({gt_o, lt_o, eq_o} == 3'b001) else $error("R3");
    if (same && {casc_gt_i, casc_lt_i, casc_eq_i} == 3'b100)
      assert_pass_gt_R4: assert ({gt_o, lt_o, eq_o} == 3'b100) else $error("R4");
    if (same && {casc_gt_i, casc_lt_i, casc_eq_i} == 3'b010)
      assert_pass_lt_R5: assert ({gt_o, lt_o, eq_o} == 3'b010) else $error("R5");
    if (same && {casc_gt_i, casc_lt_i, casc_eq_i} == 3'b110)
      assert_both_R6: assert ({gt_o, lt_o, eq_o} == 3'b000) else $error("R6");
    if (same && {casc_gt_i, casc_lt_i, casc_eq_i} == 3'b000)
      assert_none_R7: assert ({gt_o, lt_o, eq_o} == 3'b110) else $error("R7");
  end
endmodule

bind mag_cmp_stage mag_cmp_stage_chk #(.DATA_W(DATA_W)) u_chk (
  .a_word    (a_word),
  .b_word    (b_word),
  .casc_gt_i (casc_gt_i),
  .casc_lt_i (casc_lt_i),
  .casc_eq_i (casc_eq_i),
  .gt_o      (gt_o),
  .lt_o      (lt_o),
  .eq_o      (eq_o)
);

// File: tb/sim_mag_cmp_stage.sv
`timescale 1ns/1ps
module sim_mag_cmp_stage;
  localparam int W = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  // single stage under test
  logic [W-1:0] a, b;
  logic gi, li, ei;
  logic go, lo, eo;

  mag_cmp_stage #(.DATA_W(W)) u0 (
    .a_word(a), .b_word(b), .casc_gt_i(gi), .casc_lt_i(li), .casc_eq_i(ei),
    .gt_o(go), .lt_o(lo), .eq_o(eo)
  );

  // two-stage ripple chain
  logic [2*W-1:0] ca, cb;
  logic m_gt, m_lt, m_eq, h_gt, h_lt, h_eq;

  mag_cmp_stage #(.DATA_W(W)) u_lo (
    .a_word(ca[W-1:0]), .b_word(cb[W-1:0]),
    .casc_gt_i(1'b0), .casc_lt_i(1'b0), .casc_eq_i(1'b1),
    .gt_o(m_gt), .lt_o(m_lt), .eq_o(m_eq)
  );
  mag_cmp_stage #(.DATA_W(W)) u_hi (
    .a_word(ca[2*W-1:W]), .b_word(cb[2*W-1:W]),
    .casc_gt_i(m_gt), .casc_lt_i(m_lt), .casc_eq_i(m_eq),
    .gt_o(h_gt), .lt_o(h_lt), .eq_o(h_eq)
  );

  function automatic logic [2:0] ref_out(int x, int y, logic g, logic l, logic e);
    if (x > y) return 3'b100;
    if (x < y) return 3'b010;
    return {~e & ~l, ~e & ~g, e};
  endfunction

  task automatic chk(string req, logic [2:0] act, logic [2:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: a=%0d b=%0d got gt/lt/eq=%b expected %b", req, a, b, act, exp);
    end
  endtask

  task automatic drive(int x, int y, logic [2:0] c);
    a = x[W-1:0]; b = y[W-1:0]; {gi, li, ei} = c;
    #1;
  endtask

  // Zero inputs after reset: equal words, all carries low -> 110 (R7).
  task automatic t_reset;
    drive(0, 0, 3'b000);
    chk("R7 idle", {go, lo, eo}, 3'b110);
  endtask

  task automatic t_msb_first;
    drive(8, 7, 3'b010); chk("R1 msb wins", {go, lo, eo}, 3'b100);
    drive(4, 11, 3'b100); chk("R1 msb loses", {go, lo, eo}, 3'b010);
    drive(6, 5, 3'b001); chk("R1 low pair", {go, lo, eo}, 3'b100);
    drive(14, 15, 3'b001); chk("R2 lsb differs", {go, lo, eo}, 3'b010);
  endtask

  task automatic t_cascade_rows;
    for (int v = 0; v < 16; v += 5) begin
      drive(v, v, 3'b101); chk("R3 eq dominates", {go, lo, eo}, 3'b001);
      drive(v, v, 3'b100); chk("R4 pass gt", {go, lo, eo}, 3'b100);
      drive(v, v, 3'b010); chk("R5 pass lt", {go, lo, eo}, 3'b010);
      drive(v, v, 3'b110); chk("R6 both high", {go, lo, eo}, 3'b000);
      drive(v, v, 3'b000); chk("R7 all low", {go, lo, eo}, 3'b110);
    end
  endtask

  // Every operand pair against every carry pattern (R1..R7).
  task automatic t_sweep;
    for (int x = 0; x < 16; x++)
      for (int y = 0; y < 16; y++)
        for (int c = 0; c < 8; c++) begin
          drive(x, y, c[2:0]);
          if (x != y) chk("R2 sweep", {go, lo, eo}, ref_out(x, y, c[2], c[1], c[0]));
          else chk("R3-R7 sweep eq", {go, lo, eo}, ref_out(x, y, c[2], c[1], c[0]));
        end
  endtask

  task automatic t_chain;
    for (int x = 0; x < 256; x++)
      for (int y = 0; y < 256; y++) begin
        ca = x[7:0]; cb = y[7:0];
        #1;
        chk("R8 chain", {h_gt, h_lt, h_eq}, ref_out(x, y, 1'b0, 1'b0, 1'b1));
      end
  endtask

  task automatic t_bcd;
    for (int x = 0; x < 100; x++)
      for (int y = 0; y < 100; y++) begin
        ca = {4'(x / 10), 4'(x % 10)};
        cb = {4'(y / 10), 4'(y % 10)};
        #1;
        chk("R9 bcd", {h_gt, h_lt, h_eq}, ref_out(x, y, 1'b0, 1'b0, 1'b1));
      end
  endtask

  initial begin
    a = '0; b = '0; gi = 1'b0; li = 1'b0; ei = 1'b0; ca = '0; cb = '0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_msb_first();
    t_cascade_rows();
    t_sweep();
    t_chain();
    t_bcd();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule